// File: doc/BRIEF.md
# Single-Wire Bus Slot Generator

This block produces the timed drive and release phases of an open-drain single-wire bus. A controller asks for one slot at a time. There are four slot kinds: a bus reset with presence detection, a write of 0, a write of 1, and a read. A touch command also exists. With a 1 it becomes a read, and with a 0 it becomes a write-0. All timing comes from a one-cycle microsecond tick supplied from outside. Every phase length is scaled by an integer stretch factor, which the block captures when the slot starts.

The block drives the line through a single drive-low enable, and the pad is expected to release the line otherwise. The returning line level enters through a two-flop synchronizer. Each slot has three parts:

- a low phase;
- a first release phase, which ends at the sample point when the slot has one;
- an optional second release phase, used for read completion or for reset recovery.

When a slot finishes, `done` pulses and `busy` falls in the same cycle.

Top module: `owire_slot_gen`

## Requirements
- R1: Command codes on `cmd` are 00 reset, 01 write (bit from `wr_bit`), 10 read, 11 touch. A write with `wr_bit`=1 holds the line low for 6*K ticks, then released for 64*K ticks, where K is the stretch factor. Afterwards `rd_bit` is 0.
- R2: A write with `wr_bit`=0 holds the line low for 60*K ticks, then released for 10*K ticks.
- R3: A read holds the line low for 6*K ticks and then releases it. It samples the synchronized line on the 9*K-th release tick and stays released for 64*K ticks in total. `rd_bit` then equals the sampled level.
- R4: A reset holds the line low for 500*K ticks. It samples on the 70*K-th release tick and then stays released for another 430*K ticks. `presence` is set to 1 if the sample was low and 0 if it was high, and `rd_bit` is left unchanged.
- R5: A touch with `wr_bit`=1 runs exactly as a read. A touch with `wr_bit`=0 runs exactly as a write-0 and leaves `rd_bit` at 0.
- R6: The stretch factor is taken from `coef` in the cycle the start is accepted, and later changes have no effect on the running slot. A `coef` of 0 acts as 1.
- R7: A start is accepted only while `busy` is low. An accepted start drives the line low from the next clock. A start raised while `busy` is high is ignored and changes neither the slot in flight nor the number of completions.
- R8: `done` is high for exactly one clock per slot, in the first cycle `busy` is low. A start presented in that cycle is accepted.
- R9: After reset `bus_drive_low`, `busy`, `done`, `rd_bit` and `presence` are all 0. While idle with no start, the line is released and `rd_bit` and `presence` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Slot request |
| cmd | input | 2 | Command code |
| wr_bit | input | 1 | Bit for write or touch |
| coef | input | COEF_W | Timing stretch factor |
| bus_in | input | 1 | Raw line level |
| bus_drive_low | output | 1 | Pull the line low when 1 |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| rd_bit | output | 1 | Last read result |
| presence | output | 1 | Device answered the last reset |

## Verification
Completion of a slot and acceptance of the next command can fall in the same clock cycle. That cycle is the one where `done` is high and `busy` has just fallen. The bench waits for `done` to rise and raises `start` in that same cycle, so the first slot hands over to the second with no idle clock between them. The handover is judged correct when the second slot begins driving low on the very next clock and its low and release tick counts are complete. A related overlap is a start raised mid-slot. It is judged by checking that the running slot keeps its length and that only one completion occurs.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_TOUCH = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SLOT_RST,
        SLOT_W0,
        SLOT_W1,
        SLOT_RD
    } slot_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_REL1,
        PH_REL2
    } phase_e;

    // Touch with 1 is a read; touch with 0 is a write-0.
    function automatic slot_e resolve_slot(cmd_e c, logic b);
        case (c)
            CMD_RESET: return SLOT_RST;
            CMD_WRITE: return b ? SLOT_W1 : SLOT_W0;
            CMD_READ:  return SLOT_RD;
            default:   return b ? SLOT_RD : SLOT_W0;
        endcase
    endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // The line idles released (high), so the stages reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/owire_phase_timer.sv
module owire_phase_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = load_val;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owire_slot_gen.sv
module owire_slot_gen
    import owire_pkg::*;
#(
    parameter int COEF_W       = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int SHORT_LOW_US = 6,
    parameter int LONG_LOW_US  = 60,
    parameter int W1_REL_US    = 64,
    parameter int W0_REL_US    = 10,
    parameter int RD_SAMPLE_US = 9,
    parameter int RD_TAIL_US   = 55,
    parameter int RST_LOW_US   = 500,
    parameter int RST_SAMPLE_US = 70,
    parameter int RST_RECOV_US = 430
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic              wr_bit,
    input  logic [COEF_W-1:0] coef,
    input  logic              bus_in,
    output logic              bus_drive_low,
    output logic              busy,
    output logic              done,
    output logic              rd_bit,
    output logic              presence
);
    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int LONGEST = max2(max2(max2(RST_LOW_US, RST_RECOV_US), max2(W1_REL_US, LONG_LOW_US)),
                                  max2(max2(RST_SAMPLE_US, RD_TAIL_US), max2(W0_REL_US, SHORT_LOW_US)));
    localparam int CNT_W = $clog2(LONGEST * ((1 << COEF_W) - 1) + 1);

    typedef struct packed {
        phase_e            phase;
        slot_e             slot;
        logic [COEF_W-1:0] k;
        logic              drive;
        logic              done;
        logic              rd_bit;
        logic              presence;
    } st_t;

    st_t              st_d, st_q;
    logic             lvl;
    logic             expire;
    logic             tload;
    logic [CNT_W-1:0] tval;
    slot_e            new_slot;
    logic [COEF_W-1:0] new_k;

    function automatic int low_us(slot_e s);
        case (s)
            SLOT_RST: return RST_LOW_US;
            SLOT_W0:  return LONG_LOW_US;
            default:  return SHORT_LOW_US;
        endcase
    endfunction

    function automatic int rel1_us(slot_e s);
        case (s)
            SLOT_RST: return RST_SAMPLE_US;
            SLOT_W0:  return W0_REL_US;
            SLOT_W1:  return W1_REL_US;
            default:  return RD_SAMPLE_US;
        endcase
    endfunction

    function automatic int rel2_us(slot_e s);
        case (s)
            SLOT_RST: return RST_RECOV_US;
            SLOT_RD:  return RD_TAIL_US;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] scale(int us, logic [COEF_W-1:0] k);
        return CNT_W'(us) * CNT_W'(k);
    endfunction

    owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (lvl)
    );

    owire_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (tload),
        .load_val (tval),
        .expire   (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tload     = 1'b0;
        tval      = '0;
        new_slot  = resolve_slot(cmd_e'(cmd), wr_bit);
        new_k     = (coef == '0) ? COEF_W'(1) : coef;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.slot  = new_slot;
                    st_d.k     = new_k;
                    st_d.phase = PH_LOW;
                    st_d.drive = 1'b1;
                    tload      = 1'b1;
                    tval       = scale(low_us(new_slot), new_k);
                end
            end
            PH_LOW: begin
                if (expire) begin
                    st_d.phase = PH_REL1;
                    st_d.drive = 1'b0;
                    tload      = 1'b1;
                    tval       = scale(rel1_us(st_q.slot), st_q.k);
                end
            end
            PH_REL1: begin
                if (expire) begin
                    if (st_q.slot == SLOT_RST)     st_d.presence = ~lvl;
                    else if (st_q.slot == SLOT_RD) st_d.rd_bit   = lvl;
                    else                           st_d.rd_bit   = 1'b0;
                    if (rel2_us(st_q.slot) != 0) begin
                        st_d.phase = PH_REL2;
                        tload      = 1'b1;
                        tval       = scale(rel2_us(st_q.slot), st_q.k);
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: begin
                if (expire) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.slot     <= SLOT_RST;
            st_q.k        <= COEF_W'(1);
            st_q.drive    <= 1'b0;
            st_q.done     <= 1'b0;
            st_q.rd_bit   <= 1'b0;
            st_q.presence <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_drive_low = st_q.drive;
    assign busy          = (st_q.phase != PH_IDLE);
    assign done          = st_q.done;
    assign rd_bit        = st_q.rd_bit;
    assign presence      = st_q.presence;
endmodule

// File: rtl/owire_slot_gen_chk.sv
module owire_slot_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bus_drive_low,
    input logic busy,
    input logic done,
    input logic rd_bit,
    input logic presence
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R8
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                             // R8
    AST_FALL_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                        // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_drive_low);                                    // R9
    AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && bus_drive_low));                // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(rd_bit) && $stable(presence))); // R9
endmodule

bind owire_slot_gen owire_slot_gen_chk u_chk (.*);

// File: tb/owire_slot_gen_bench.sv
module owire_slot_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       wr_bit = 1'b0;
    logic [3:0] coef = 4'd1;
    logic       bus_in;
    logic       bus_drive_low, busy, done, rd_bit, presence;
    logic       dev_pull = 1'b0;

    int n_chk = 0, n_fail = 0;
    int low_t = 0, rel_t = 0, done_cnt = 0, div = 0;
    int pull_lo = 0, pull_hi = 0;
    bit pull_en = 1'b0;

    always #5 clk = ~clk;

    assign bus_in = ~(bus_drive_low | dev_pull);

    owire_slot_gen u_owire_slot_gen (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .cmd(cmd),
        .wr_bit(wr_bit), .coef(coef), .bus_in(bus_in), .bus_drive_low(bus_drive_low),
        .busy(busy), .done(done), .rd_bit(rd_bit), .presence(presence)
    );

    initial begin
        forever begin
            @(posedge clk); #1;
            div     = (div == 2) ? 0 : div + 1;
            us_tick = (div == 0);
        end
    end

    // Tick counting per phase plus a device model that pulls during a release window.
    always @(negedge clk) begin
        if (bus_drive_low)  low_t = low_t + int'(us_tick);
        else if (busy)      rel_t = rel_t + int'(us_tick);
        if (done)           done_cnt = done_cnt + 1;
        dev_pull = pull_en && busy && !bus_drive_low && rel_t >= pull_lo && rel_t < pull_hi;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic set_dev(input bit en, input int lo, input int hi);
        pull_en = en; pull_lo = lo; pull_hi = hi;
    endtask

    // Present a start in the current cycle (caller stands just after a rising edge).
    task automatic issue_now(input logic [1:0] c, input logic b, input logic [3:0] k);
        cmd = c; wr_bit = b; coef = k; start = 1'b1;
        low_t = 0; rel_t = 0; done_cnt = 0;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic issue(input logic [1:0] c, input logic b, input logic [3:0] k);
        @(posedge clk); #1;
        issue_now(c, b, k);
    endtask

    task automatic wait_done();
        while (!done) begin @(posedge clk); #1; end
    endtask

    task automatic t_reset_state();
        check("R9 drive", int'(bus_drive_low), 0);
        check("R9 busy", int'(busy), 0);
        check("R9 done", int'(done), 0);
        check("R9 rd_bit", int'(rd_bit), 0);
        check("R9 presence", int'(presence), 0);
    endtask

    task automatic t_write1();
        set_dev(0, 0, 0);
        issue(2'b01, 1'b1, 4'd1); wait_done();
        check("R1 low", low_t, 6); check("R1 rel", rel_t, 64); check("R1 rd", int'(rd_bit), 0);
    endtask

    task automatic t_write0();
        issue(2'b01, 1'b0, 4'd1); wait_done();
        check("R2 low", low_t, 60); check("R2 rel", rel_t, 10);
    endtask

    task automatic t_read_low();
        set_dev(1, 8, 1000);
        issue(2'b10, 1'b0, 4'd1); wait_done();
        check("R3 low", low_t, 6); check("R3 rel", rel_t, 64); check("R3 rd late pull", int'(rd_bit), 0);
    endtask

    task automatic t_read_early();
        set_dev(1, 0, 8);
        issue(2'b10, 1'b0, 4'd1); wait_done();
        check("R3 rd early pull", int'(rd_bit), 1);
        set_dev(0, 0, 0);
    endtask

    task automatic t_touch1();
        set_dev(0, 0, 0);
        issue(2'b11, 1'b1, 4'd1); wait_done();
        check("R5 touch1 low", low_t, 6); check("R5 touch1 rel", rel_t, 64); check("R5 touch1 rd", int'(rd_bit), 1);
    endtask

    task automatic t_reset_present();
        set_dev(1, 69, 300);
        issue(2'b00, 1'b0, 4'd1); wait_done();
        check("R4 low", low_t, 500); check("R4 rel", rel_t, 500);
        check("R4 presence", int'(presence), 1); check("R4 rd kept", int'(rd_bit), 1);
        set_dev(0, 0, 0);
    endtask

    task automatic t_reset_absent();
        issue(2'b00, 1'b0, 4'd1); wait_done();
        check("R4 absent", int'(presence), 0);
    endtask

    task automatic t_touch0();
        issue(2'b11, 1'b0, 4'd1); wait_done();
        check("R5 touch0 low", low_t, 60); check("R5 touch0 rel", rel_t, 10); check("R5 touch0 rd", int'(rd_bit), 0);
    endtask

    task automatic t_coef_latch();
        issue(2'b01, 1'b1, 4'd2);
        repeat (10) @(posedge clk);
        #1 coef = 4'd5;
        wait_done();
        check("R6 latched low", low_t, 12); check("R6 latched rel", rel_t, 128);
    endtask

    task automatic t_coef_zero();
        issue(2'b01, 1'b0, 4'd0); wait_done();
        check("R6 zero low", low_t, 60); check("R6 zero rel", rel_t, 10);
    endtask

    task automatic t_read_stretched();
        set_dev(1, 26, 1000);
        issue(2'b10, 1'b1, 4'd3); wait_done();
        check("R6 k3 low", low_t, 18); check("R6 k3 rel", rel_t, 192); check("R3 k3 rd", int'(rd_bit), 0);
        set_dev(0, 0, 0);
    endtask

    task automatic t_ignore_busy();
        issue(2'b01, 1'b0, 4'd1);
        repeat (20) @(posedge clk);
        #1 cmd = 2'b00; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_done();
        check("R7 low", low_t, 60); check("R7 rel", rel_t, 10);
        repeat (60) @(posedge clk);
        #1;
        check("R7 one done", done_cnt, 1); check("R7 idle", int'(busy), 0);
    endtask

    task automatic t_back_to_back();
        issue(2'b10, 1'b0, 4'd1); wait_done();
        check("R8 done with idle", int'(busy), 0);
        issue_now(2'b01, 1'b1, 4'd1);
        check("R8 accepted in done cycle", int'(bus_drive_low), 1);
        wait_done();
        check("R8 second low", low_t, 6); check("R8 second rel", rel_t, 64);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        t_write1();
        t_write0();
        t_read_low();
        t_read_early();
        t_touch1();
        t_reset_present();
        t_reset_absent();
        t_touch0();
        t_coef_latch();
        t_coef_zero();
        t_read_stretched();
        t_ignore_busy();
        t_back_to_back();
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule